// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block decides, frame by frame, whether a progressive-scan image sensor is read out, and where in each frame the charge-sweep and readout events fall. A frame strobe marks the start of each frame and a line strobe marks each line. Two shutters work together. A frame-skip setting withholds readout for a programmed number of frames, which stretches exposure in whole-frame units. A sweep count sets how many charge-sweep (SUB) pulses are issued in a readout frame, which trims exposure in line units. An exposure indicator stays high while charge is being collected.

Settings are taken from the configuration inputs only at the frame strobe of a frame that will be read out. During withheld frames the active settings stay frozen, so a new value never lands partway through a long exposure. A partial-sweep mode moves the readout point further into the frame and disables frame skipping. Readout pulse, sweep pulse and indicator changes are registered and appear on the clock edge that follows the line strobe that triggers them.

Top module: `ccd_shutter_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, all outputs are low. Line strobes seen before the first frame strobe produce no pulses. The first frame strobe after reset starts a readout frame.
- R2: With a skip value N loaded at a readout frame, the next N frame strobes start withheld frames, and the strobe after them starts a readout frame.
- R3: With a skip value of 0, every frame is a readout frame.
- R4: Lines are counted from 1 at the first line strobe after a frame strobe. In a readout frame with normal mode, `read_pulse` is high for one cycle, on the edge after the strobe of line 6.
- R5: With `sweep_mode` active, the readout pulse falls on line 76 instead of line 6, and the skip value is ignored, so every frame is read out.
- R6: In a readout frame with sweep count N, `sub_pulse` is high for one cycle after each of the line strobes for lines 1 to N. N = 0 issues none. Withheld frames issue none.
- R7: When `read_inhibit` is active in a readout frame, no readout pulse is issued. Sweep pulses and the indicator behave as without inhibit.
- R8: The exposure indicator falls on the edge after the readout-position line strobe. It rises on the edge after the strobe of line max(readout line, N) + 1. Otherwise it holds, including through withheld frames.
- R9: `exp_disable` forces `exp_out` low in the same cycle it is asserted. Clearing it restores the indicator state at once.
- R10: The skip value, sweep count, inhibit and mode inputs are sampled only at the strobe of a readout frame. Changes made during withheld frames have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fr_strobe | input | 1 | One-cycle frame start strobe |
| hr_strobe | input | 1 | One-cycle line strobe |
| lo_skip | input | 5 | Frames to withhold readout |
| hi_sub_cnt | input | 11 | Sweep pulses per readout frame |
| read_inhibit | input | 1 | Suppress the readout pulse |
| exp_disable | input | 1 | Hold the exposure indicator low |
| sweep_mode | input | 1 | Partial-sweep mode (readout at line 76, no skipping) |
| read_pulse | output | 1 | Readout pulse |
| sub_pulse | output | 1 | Charge-sweep pulse |
| exp_out | output | 1 | Exposure indicator |

## Verification
The assertions assume that strobes last one cycle, that a frame strobe and a line strobe never share a cycle, and that consecutive line strobes are at least one idle cycle apart. Under these assumptions each line produces at most one readout pulse. The stimulus follows these assumptions. Every strobe is a single cycle, each line strobe is followed by three idle cycles, and the frame strobe gets a cycle of its own. Configuration inputs change only on falling edges between lines, never in the cycle the monitor samples.

// File: rtl/ccd_shutter_pkg.sv
package ccd_shutter_pkg;

    localparam int SKIP_W = 5;
    localparam int SUB_W  = 11;
    localparam int LINE_W = 11;

    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [SUB_W-1:0]  sub;
        logic              noread;
        logic              fs;
    } shut_cfg_t;

    // Line on which the indicator rises again: one past the later of the
    // readout line and the last sweep line.
    function automatic logic [LINE_W:0] rise_line(input logic [LINE_W-1:0] rd,
                                                  input logic [SUB_W-1:0]  sub);
        logic [LINE_W:0] a;
        logic [LINE_W:0] b;
        a = {1'b0, rd};
        b = (LINE_W + 1)'(sub);
        return ((a > b) ? a : b) + 1'b1;
    endfunction

endpackage

// File: rtl/shutter_frame_ctrl.sv
module shutter_frame_ctrl
    import ccd_shutter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fr,
    input  shut_cfg_t cfg_in,
    output shut_cfg_t act,
    output logic      frame_rd
);

    logic [SKIP_W-1:0] skip_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_cnt <= '0;
            act      <= '0;
            frame_rd <= 1'b0;
        end else if (fr) begin
            if (skip_cnt == '0) begin
                frame_rd <= 1'b1;
                act      <= cfg_in;
                skip_cnt <= cfg_in.fs ? '0 : cfg_in.skip;
            end else begin
                frame_rd <= 1'b0;
                skip_cnt <= skip_cnt - 1'b1;
            end
        end
    end

    AST_SKIP_WITHHOLD: assert property (@(posedge clk) disable iff (rst)
        (fr && skip_cnt != '0) |=> !frame_rd); // R2

    AST_FS_EVERY_FRAME: assert property (@(posedge clk) disable iff (rst)
        (fr && frame_rd && act.fs) |=> frame_rd); // R5

endmodule

// File: rtl/shutter_line_ctrl.sv
module shutter_line_ctrl #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fr,
    input  logic              hr,
    output logic [LINE_W-1:0] line_next
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_cnt;

    assign line_next = (line_cnt == LINE_MAX) ? LINE_MAX : line_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
        end else if (fr) begin
            line_cnt <= '0;
        end else if (hr) begin
            line_cnt <= line_next;
        end
    end

    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
        fr |=> (line_next == LINE_W'(1))); // R4

endmodule

// File: rtl/shutter_pulse_gen.sv
module shutter_pulse_gen
    import ccd_shutter_pkg::*;
#(
    parameter int RD_LINE_NORM = 6,
    parameter int RD_LINE_FS   = 76
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fr,
    input  logic              hr,
    input  logic              frame_rd,
    input  shut_cfg_t         act,
    input  logic [LINE_W-1:0] line_next,
    output logic              read_q,
    output logic              sub_q,
    output logic              exp_q
);

    logic [LINE_W-1:0] rd_line;
    logic [LINE_W:0]   up_line;
    logic              ev;
    logic              rd_hit;
    logic              sub_hit;

    assign rd_line = act.fs ? LINE_W'(RD_LINE_FS) : LINE_W'(RD_LINE_NORM);
    assign up_line = rise_line(rd_line, act.sub);
    assign ev      = hr && !fr && frame_rd;
    assign rd_hit  = (line_next == rd_line);
    assign sub_hit = (act.sub != '0) && ((SUB_W)'(line_next) <= act.sub);

    always_ff @(posedge clk) begin
        if (rst) begin
            read_q <= 1'b0;
            sub_q  <= 1'b0;
            exp_q  <= 1'b0;
        end else begin
            read_q <= ev && rd_hit && !act.noread;
            sub_q  <= ev && sub_hit;
            if (ev) begin
                if (rd_hit)
                    exp_q <= 1'b0;
                else if ({1'b0, line_next} == up_line)
                    exp_q <= 1'b1;
            end
        end
    end

    AST_READ_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        read_q |-> ($past(hr) && $past(frame_rd))); // R4

    AST_READ_INHIBITED: assert property (@(posedge clk) disable iff (rst)
        read_q |-> !$past(act.noread)); // R7

    AST_EXP_LOW_AT_READ: assert property (@(posedge clk) disable iff (rst)
        read_q |-> !exp_q); // R8

    AST_SUB_NONZERO: assert property (@(posedge clk) disable iff (rst)
        sub_q |-> ($past(act.sub) != '0)); // R6

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        read_q |=> !read_q); // R4

endmodule

// File: rtl/ccd_shutter_ctrl.sv
module ccd_shutter_ctrl
    import ccd_shutter_pkg::*;
#(
    parameter int RD_LINE_NORM = 6,
    parameter int RD_LINE_FS   = 76
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fr_strobe,
    input  logic              hr_strobe,
    input  logic [SKIP_W-1:0] lo_skip,
    input  logic [SUB_W-1:0]  hi_sub_cnt,
    input  logic              read_inhibit,
    input  logic              exp_disable,
    input  logic              sweep_mode,
    output logic              read_pulse,
    output logic              sub_pulse,
    output logic              exp_out
);

    shut_cfg_t         cfg_in;
    shut_cfg_t         act;
    logic              frame_rd;
    logic [LINE_W-1:0] line_next;
    logic              exp_q;

    assign cfg_in = '{skip: lo_skip, sub: hi_sub_cnt, noread: read_inhibit, fs: sweep_mode};

    shutter_frame_ctrl u_frame (
        .clk      (clk),
        .rst      (rst),
        .fr       (fr_strobe),
        .cfg_in   (cfg_in),
        .act      (act),
        .frame_rd (frame_rd)
    );

    shutter_line_ctrl #(.LINE_W(LINE_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .fr        (fr_strobe),
        .hr        (hr_strobe),
        .line_next (line_next)
    );

    shutter_pulse_gen #(
        .RD_LINE_NORM (RD_LINE_NORM),
        .RD_LINE_FS   (RD_LINE_FS)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .fr        (fr_strobe),
        .hr        (hr_strobe),
        .frame_rd  (frame_rd),
        .act       (act),
        .line_next (line_next),
        .read_q    (read_pulse),
        .sub_q     (sub_pulse),
        .exp_q     (exp_q)
    );

    assign exp_out = exp_q && !exp_disable;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!read_pulse && !sub_pulse && !exp_q)); // R1

endmodule

// File: tb/test_ccd_shutter_ctrl.sv
`timescale 1ns/1ps
module test_ccd_shutter_ctrl;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fr_strobe = 1'b0;
    logic        hr_strobe = 1'b0;
    logic [4:0]  lo_skip = '0;
    logic [10:0] hi_sub_cnt = '0;
    logic        read_inhibit = 1'b0;
    logic        exp_disable = 1'b0;
    logic        sweep_mode = 1'b0;
    logic        read_pulse, sub_pulse, exp_out;

    always #(CLK_P/2) clk = ~clk;

    ccd_shutter_ctrl i_ccd_shutter_ctrl (
        .clk(clk), .rst(rst), .fr_strobe(fr_strobe), .hr_strobe(hr_strobe),
        .lo_skip(lo_skip), .hi_sub_cnt(hi_sub_cnt), .read_inhibit(read_inhibit),
        .exp_disable(exp_disable), .sweep_mode(sweep_mode),
        .read_pulse(read_pulse), .sub_pulse(sub_pulse), .exp_out(exp_out)
    );

    typedef struct {
        bit    rd;
        bit    sb;
        bit    ex;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R1";

    // independent model
    int m_skip_rem = 0;
    int m_sub = 0;
    bit m_noread = 0;
    bit m_fs = 0;
    bit m_rd = 0;
    bit m_exp = 0;
    int m_line = 0;

    task automatic chk(string tag, logic act, logic expv, string what);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, expv);
        end
    endtask

    // monitor: compares outputs on the falling edge after each line strobe
    logic hr_d = 1'b0;
    always @(posedge clk) hr_d <= hr_strobe;

    always @(negedge clk) begin
        if (hr_d) begin
            if (q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL %s scoreboard: actual=empty expected=item", cur_tag);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, read_pulse, it.rd, "read_pulse");
                chk(it.tag, sub_pulse,  it.sb, "sub_pulse");
                chk(it.tag, exp_out,    it.ex, "exp_out");
            end
        end
    end

    task automatic do_line();
        item_t it;
        int rdl;
        int up;
        @(negedge clk);
        m_line++;
        rdl = m_fs ? 76 : 6;
        up  = ((rdl > m_sub) ? rdl : m_sub) + 1;
        it.rd = 0;
        it.sb = 0;
        if (m_rd) begin
            it.rd = (m_line == rdl) && !m_noread;
            it.sb = (m_sub != 0) && (m_line <= m_sub);
            if (m_line == rdl) m_exp = 0;
            else if (m_line == up) m_exp = 1;
        end
        it.ex  = m_exp && !exp_disable;
        it.tag = cur_tag;
        q.push_back(it);
        hr_strobe = 1'b1;
        @(negedge clk);
        hr_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_frame(int nlines);
        @(negedge clk);
        if (m_skip_rem == 0) begin
            m_rd = 1;
            m_sub = int'(hi_sub_cnt);
            m_noread = read_inhibit;
            m_fs = sweep_mode;
            m_skip_rem = sweep_mode ? 0 : int'(lo_skip);
        end else begin
            m_rd = 0;
            m_skip_rem--;
        end
        m_line = 0;
        fr_strobe = 1'b1;
        @(negedge clk);
        fr_strobe = 1'b0;
        for (int i = 0; i < nlines; i++) do_line();
    endtask

    bit finished = 0;

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low in reset
        chk("R1", read_pulse, 1'b0, "read_pulse in reset");
        chk("R1", sub_pulse,  1'b0, "sub_pulse in reset");
        chk("R1", exp_out,    1'b0, "exp_out in reset");
        rst = 1'b0;
        @(negedge clk);
        // R1: lines before any frame strobe give nothing
        hi_sub_cnt = 11'd3;
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) do_line();

        // R3 R4 R6 R8: skip 0, sweep count 3, every frame reads at line 6
        cur_tag = "R3";
        do_frame(10);
        cur_tag = "R4";
        do_frame(10);

        // R8: sweep count past readout line, indicator rises at line 10
        hi_sub_cnt = 11'd9;
        cur_tag = "R8";
        do_frame(12);

        // R9: disable forces indicator low at once
        chk("R8", exp_out, 1'b1, "exp_out high after rise");
        exp_disable = 1'b1;
        #1;
        chk("R9", exp_out, 1'b0, "exp_out with disable");
        @(negedge clk);
        exp_disable = 1'b0;
        #1;
        chk("R9", exp_out, 1'b1, "exp_out after disable cleared");

        // R2 R6: skip 2 with no sweep pulses
        lo_skip = 5'd2;
        hi_sub_cnt = 11'd0;
        cur_tag = "R2";
        do_frame(8);
        // R10: change settings during withheld frames
        hi_sub_cnt = 11'd4;
        lo_skip = 5'd0;
        cur_tag = "R10";
        do_frame(8);
        do_frame(8);
        cur_tag = "R2";
        do_frame(8);
        cur_tag = "R6";
        do_frame(8);

        // R7: readout inhibited
        read_inhibit = 1'b1;
        hi_sub_cnt = 11'd2;
        cur_tag = "R7";
        do_frame(8);
        read_inhibit = 1'b0;

        // R5: partial-sweep mode, skip ignored, readout at line 76
        sweep_mode = 1'b1;
        lo_skip = 5'd3;
        hi_sub_cnt = 11'd5;
        cur_tag = "R5";
        do_frame(80);
        do_frame(80);
        sweep_mode = 1'b0;
        lo_skip = 5'd0;
        do_frame(8);

        repeat (4) @(negedge clk);
        chk("R1", (q.size() == 0), 1'b1, "scoreboard drained");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule